// File: doc/BRIEF.md
# SNR-Selected Beamforming Matrix Controller

This block sits between a channel estimator and a spatial combiner. It takes an M×K complex channel matrix and produces a K×M beamforming matrix. A two-bit SNR code picks the method. In the low-SNR method the block forms the conjugate transpose of the channel matrix itself, in one cycle. In the high-SNR method (zero forcing) and the intermediate method (regularized inversion) it runs three external engines in a fixed order, using start/done pairs. The first engine forms the Gram product. The second inverts it and, in the regularized method, adds the noise variance to the diagonal first. The third forms the final product. The block never divides. The inverter reports an unresolved normalization coefficient, and the block hands that coefficient downstream together with the matrix.

Upstream uses a valid/ready handshake. The block latches the channel matrix, the SNR code and the noise variance when it accepts them. The engines read the latched copy of the matrix. Downstream sees a single-cycle valid pulse. The matrix and coefficient outputs then hold until the next completion.

Top module: `bf_matrix_ctrl`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, all three start outputs, `g_out` and `coef_out` are 0.
- R2: The SNR code selects the method. Code 2'b00 selects conjugate. Code 2'b10 selects zero forcing. Codes 2'b01 and 2'b11 select regularized inversion.
- R3: Each complex entry is 2·DW bits wide, with the real part in the upper DW bits and the imaginary part in the lower DW bits. H entry (m,k) sits at flat index m·K+k and G entry (k,m) at flat index k·M+m. In conjugate mode, G(k,m) takes the real part of H(m,k) and the two's-complement negation of its imaginary part (the most negative value maps to itself). In this mode `out_valid` pulses in the cycle after acceptance and `coef_out` equals 2^FRAC (64 by default).
- R4: A transfer is accepted only in a cycle where both `in_valid` and `in_ready` are high. After a non-conjugate acceptance, `in_ready` stays low until the cycle in which `out_valid` pulses.
- R5: In a non-conjugate run, `gram_start` pulses in the cycle after acceptance. `inv_start` pulses in the cycle after `gram_done`, and `mul_start` pulses in the cycle after `inv_done`. `out_valid` pulses in the cycle after `mul_done`, and `g_out` then equals the `mul_g` that was presented with `mul_done`.
- R6: `inv_diag_add` equals the latched noise variance in regularized mode and 0 in zero-forcing mode. It is set at acceptance.
- R7: In non-conjugate mode, `coef_out` at completion equals the `inv_coef` value that was presented with `inv_done`.
- R8: `out_valid` is a single-cycle pulse for each completion. Between pulses, `g_out` and `coef_out` keep their values.
- R9: A done input that arrives while its own engine step is not active has no effect: no start pulse follows and no completion follows.
- R10: Changes to `chan_h`, `snr_code`, `noise_var` or `in_valid` while a run is in progress have no effect. `eng_chan`, `inv_diag_add` and the selected method stay as they were latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a channel matrix |
| in_ready | output | 1 | Block can accept a new matrix |
| chan_h | input | M·K·2·DW | Flattened channel matrix |
| snr_code | input | 2 | Method selection code |
| noise_var | input | DW | Noise variance for regularized mode |
| eng_chan | output | M·K·2·DW | Latched channel matrix for the engines |
| gram_start | output | 1 | Start pulse for the Gram multiplier |
| gram_done | input | 1 | Gram multiplier finished |
| inv_start | output | 1 | Start pulse for the inverter |
| inv_diag_add | output | DW | Value the inverter adds to the diagonal |
| inv_done | input | 1 | Inverter finished |
| inv_coef | input | DW | Normalization coefficient from the inverter |
| mul_start | output | 1 | Start pulse for the final multiplier |
| mul_done | input | 1 | Final multiplier finished |
| mul_g | input | K·M·2·DW | Result matrix from the final multiplier |
| out_valid | output | 1 | Single-cycle completion pulse |
| g_out | output | K·M·2·DW | Beamforming matrix |
| coef_out | output | DW | Forwarded normalization coefficient |

## Verification
The assertions assume that the engines raise each done input for exactly one cycle. They do not require this to happen only during the matching step, because the requirements define what happens to a done that arrives at the wrong time. The stimulus drives every done as a one-cycle pulse. It does send deliberately misplaced dones, and it changes the upstream inputs while a run is in progress. It never offers a new transfer in the same cycle as a conjugate completion, so the single-pulse property is checked without back-to-back acceptance.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [1:0] {MODE_CONJ, MODE_ZF, MODE_REG} bf_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_GRAM, ST_INV, ST_MUL} bf_state_e;

  // SNR code to method: low -> conjugate, high -> zero forcing, else regularized
  function automatic bf_mode_e decode_snr(input logic [1:0] code);
    case (code)
      2'b00:   return MODE_CONJ;
      2'b10:   return MODE_ZF;
      default: return MODE_REG;
    endcase
  endfunction
endpackage

// File: rtl/bf_conj_xpose.sv
module bf_conj_xpose #(
  parameter int M  = 3,
  parameter int K  = 2,
  parameter int DW = 8
) (
  input  logic [M*K*2*DW-1:0] h_flat,
  output logic [K*M*2*DW-1:0] g_flat
);
  localparam int EW = 2 * DW;

  function automatic logic [DW-1:0] neg_part(input logic [DW-1:0] v);
    return ~v + 1'b1;
  endfunction

  for (genvar m = 0; m < M; m++) begin : g_row
    for (genvar k = 0; k < K; k++) begin : g_col
      localparam int SRC = (m * K + k) * EW;
      localparam int DST = (k * M + m) * EW;
      assign g_flat[DST+DW +: DW] = h_flat[SRC+DW +: DW];
      assign g_flat[DST +: DW]    = neg_part(h_flat[SRC +: DW]);
    end
  end
endmodule

// File: rtl/bf_seq_fsm.sv
module bf_seq_fsm
  import bf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept_seq,
  input  logic gram_done,
  input  logic inv_done,
  input  logic mul_done,
  output logic busy,
  output logic gram_start,
  output logic inv_start,
  output logic mul_start,
  output logic inv_fin,
  output logic mul_fin
);
  bf_state_e state;

  assign busy    = (state != ST_IDLE);
  assign inv_fin = (state == ST_INV) && inv_done;
  assign mul_fin = (state == ST_MUL) && mul_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      gram_start <= 1'b0;
      inv_start  <= 1'b0;
      mul_start  <= 1'b0;
    end else begin
      gram_start <= 1'b0;
      inv_start  <= 1'b0;
      mul_start  <= 1'b0;
      case (state)
        ST_IDLE: if (accept_seq) begin
          state      <= ST_GRAM;
          gram_start <= 1'b1;
        end
        ST_GRAM: if (gram_done) begin
          state     <= ST_INV;
          inv_start <= 1'b1;
        end
        ST_INV: if (inv_done) begin
          state     <= ST_MUL;
          mul_start <= 1'b1;
        end
        default: if (mul_done) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bf_matrix_ctrl.sv
module bf_matrix_ctrl
  import bf_pkg::*;
#(
  parameter int M    = 3,
  parameter int K    = 2,
  parameter int DW   = 8,
  parameter int FRAC = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [M*K*2*DW-1:0]  chan_h,
  input  logic [1:0]           snr_code,
  input  logic [DW-1:0]        noise_var,
  output logic [M*K*2*DW-1:0]  eng_chan,
  output logic                 gram_start,
  input  logic                 gram_done,
  output logic                 inv_start,
  output logic [DW-1:0]        inv_diag_add,
  input  logic                 inv_done,
  input  logic [DW-1:0]        inv_coef,
  output logic                 mul_start,
  input  logic                 mul_done,
  input  logic [K*M*2*DW-1:0]  mul_g,
  output logic                 out_valid,
  output logic [K*M*2*DW-1:0]  g_out,
  output logic [DW-1:0]        coef_out
);
  localparam int GW = K * M * 2 * DW;
  localparam int HW = M * K * 2 * DW;
  localparam logic [DW-1:0] COEF_ONE = DW'(1) << FRAC;

  bf_mode_e        in_mode;
  logic            accept_evt, accept_conj, accept_seq;
  logic            busy, inv_fin, mul_fin;
  logic [GW-1:0]   xpose_g;
  logic [DW-1:0]   coef_lat;

  assign in_mode     = decode_snr(snr_code);
  assign in_ready    = !busy;
  assign accept_evt  = in_valid && in_ready;
  assign accept_conj = accept_evt && (in_mode == MODE_CONJ);
  assign accept_seq  = accept_evt && (in_mode != MODE_CONJ);

  bf_conj_xpose #(.M(M), .K(K), .DW(DW)) u_xpose (
    .h_flat (chan_h),
    .g_flat (xpose_g)
  );

  bf_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_seq (accept_seq),
    .gram_done  (gram_done),
    .inv_done   (inv_done),
    .mul_done   (mul_done),
    .busy       (busy),
    .gram_start (gram_start),
    .inv_start  (inv_start),
    .mul_start  (mul_start),
    .inv_fin    (inv_fin),
    .mul_fin    (mul_fin)
  );

  // operand latches, written only at acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_chan     <= '0;
      inv_diag_add <= '0;
    end else if (accept_evt) begin
      eng_chan     <= chan_h;
      inv_diag_add <= (in_mode == MODE_REG) ? noise_var : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       coef_lat <= '0;
    else if (inv_fin) coef_lat <= inv_coef;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_out     <= '0;
      coef_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept_conj) begin
        g_out     <= xpose_g;
        coef_out  <= COEF_ONE;
        out_valid <= 1'b1;
      end else if (mul_fin) begin
        g_out     <= mul_g;
        coef_out  <= coef_lat;
        out_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bf_matrix_ctrl_chk.sv
module bf_matrix_ctrl_chk #(
  parameter int GW = 96,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    snr_code,
  input logic [CW-1:0] noise_var,
  input logic [CW-1:0] inv_diag_add,
  input logic          gram_start,
  input logic          inv_start,
  input logic          mul_start,
  input logic          out_valid,
  input logic [GW-1:0] g_out,
  input logic [CW-1:0] coef_out
);
  logic acc, acc_conj;
  assign acc      = in_valid && in_ready;
  assign acc_conj = acc && (snr_code == 2'b00);

  a_r3_conj_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_conj |=> out_valid);
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_conj) |=> !in_ready);
  a_r5_gram_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !acc_conj) |=> gram_start);
  a_r5_starts_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gram_start, inv_start, mul_start}));
  a_r6_zf_no_diag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && snr_code == 2'b10) |=> inv_diag_add == '0);
  a_r6_reg_diag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && snr_code[0]) |=> inv_diag_add == $past(noise_var));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !acc_conj) |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(g_out) && $stable(coef_out)));
  a_r10_diag_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(inv_diag_add));
endmodule

bind bf_matrix_ctrl bf_matrix_ctrl_chk #(.GW(GW), .CW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .snr_code     (snr_code),
  .noise_var    (noise_var),
  .inv_diag_add (inv_diag_add),
  .gram_start   (gram_start),
  .inv_start    (inv_start),
  .mul_start    (mul_start),
  .out_valid    (out_valid),
  .g_out        (g_out),
  .coef_out     (coef_out)
);

// File: tb/bf_matrix_ctrl_test.sv
module bf_matrix_ctrl_test;
  localparam int M = 3, K = 2, DW = 8, FRAC = 6;
  localparam int HW = M*K*2*DW, GW = K*M*2*DW;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, gram_done = 0, inv_done = 0, mul_done = 0;
  logic [HW-1:0] chan_h = '0;
  logic [1:0] snr_code = 0;
  logic [DW-1:0] noise_var = 0, inv_coef = 0;
  logic [GW-1:0] mul_g = '0;
  logic in_ready, gram_start, inv_start, mul_start, out_valid;
  logic [HW-1:0] eng_chan;
  logic [DW-1:0] inv_diag_add, coef_out;
  logic [GW-1:0] g_out;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf_matrix_ctrl #(.M(M), .K(K), .DW(DW), .FRAC(FRAC)) uut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [GW-1:0] ref_conj(input logic [HW-1:0] h);
    logic [GW-1:0] g = '0;
    for (int r = 0; r < M; r++)
      for (int c = 0; c < K; c++) begin
        logic [DW-1:0] re = h[(r*K+c)*2*DW+DW +: DW];
        logic [DW-1:0] im = h[(r*K+c)*2*DW +: DW];
        g[(c*M+r)*2*DW +: 2*DW] = {re, DW'(0 - im)};
      end
    return g;
  endfunction

  // drive one transfer; returns at the negedge after the accepting edge
  task automatic offer(input logic [1:0] code, input logic [HW-1:0] h, input logic [DW-1:0] nv);
    @(negedge clk);
    in_valid = 1; snr_code = code; chan_h = h; noise_var = nv;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 starts", {gram_start, inv_start, mul_start}, 0);
    chk("R1 g_out", g_out, 0);
    chk("R1 coef_out", coef_out, 0);
  endtask

  task automatic t_conj(input logic [HW-1:0] h);
    offer(2'b00, h, 8'd33);
    chk("R3 out_valid", out_valid, 1);
    chk("R3 g_out", g_out, ref_conj(h));
    chk("R3 coef one", coef_out, 64);
    chk("R2 conj no gram_start", gram_start, 0);
    chk("R4 ready at pulse", in_ready, 1);
    @(negedge clk);
    chk("R8 pulse ends", out_valid, 0);
    chk("R8 g holds", g_out, ref_conj(h));
  endtask

  task automatic t_seq(input logic [1:0] code, input logic [HW-1:0] h, input logic [DW-1:0] nv,
                       input logic [DW-1:0] cf, input logic [GW-1:0] gres, input bit disturb);
    logic [DW-1:0] exp_diag = (code[0]) ? nv : 8'd0;
    offer(code, h, nv);
    chk("R5 gram_start", gram_start, 1);
    chk("R4 ready low", in_ready, 0);
    chk("R6 diag", inv_diag_add, exp_diag);
    if (disturb) begin
      in_valid = 1; snr_code = ~code; chan_h = ~h; noise_var = nv + 8'd7;
      inv_done = 1; mul_done = 1;
      @(negedge clk);
      inv_done = 0; mul_done = 0; in_valid = 0;
      chk("R9 no inv_start", inv_start, 0);
      chk("R9 no mul_start", mul_start, 0);
      chk("R9 no out_valid", out_valid, 0);
      chk("R10 eng_chan", eng_chan, h);
      chk("R10 diag", inv_diag_add, exp_diag);
      chk("R10 ready low", in_ready, 0);
    end
    @(negedge clk);
    chk("R5 gram pulse", gram_start, 0);
    gram_done = 1;
    @(negedge clk);
    gram_done = 0;
    chk("R5 inv_start", inv_start, 1);
    inv_done = 1; inv_coef = cf;
    @(negedge clk);
    inv_done = 0; inv_coef = 8'hEE;
    chk("R5 mul_start", mul_start, 1);
    chk("R4 still busy", in_ready, 0);
    mul_done = 1; mul_g = gres;
    @(negedge clk);
    mul_done = 0; mul_g = '1;
    chk("R5 out_valid", out_valid, 1);
    chk("R5 g_out", g_out, gres);
    chk("R7 coef", coef_out, cf);
    chk("R4 ready back", in_ready, 1);
    @(negedge clk);
    chk("R8 pulse ends", out_valid, 0);
    chk("R8 g holds", g_out, gres);
    chk("R8 coef holds", coef_out, cf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_conj({8'd1,8'd2, 8'd3,8'hFD, 8'd5,8'd0, 8'h80,8'h80, 8'd9,8'd10, 8'h7F,8'd1});
    t_conj({12{8'h5A}});
    t_seq(2'b10, {12{8'h11}}, 8'd5, 8'd42, {12{8'hA5}}, 0);
    t_seq(2'b01, {12{8'h22}}, 8'd9, 8'd17, {12{8'h3C}}, 0);
    t_seq(2'b11, {12{8'h33}}, 8'd12, 8'd99, {12{8'h0F}}, 0);
    t_seq(2'b10, {12{8'h44}}, 8'd6, 8'd7, {12{8'hC3}}, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule